// File: doc/BRIEF.md
# Level-Dependent Compression Gain Computer

This block works out a compression gain in decibels for each audio sample it is given. Samples arrive one at a time, each tagged with a channel number, and the left and right channels take turns. For every sample the block updates that channel's peak detector. The detector rises at once to a louder input. It falls back slowly, by a fixed fraction per sample of that channel, which gives a recovery time constant of 8192 samples per channel.

The held peak is turned into a level in dB relative to full scale. That level is then applied to one of six input-to-output compression curves, or to a bypass, picked by a 3-bit code. The result is a signed fixed-point gain. A later multiplier stage turns it into a linear factor and applies it to the audio.

Levels and gains use a signed 12-bit word with 4 fraction bits, so one LSB is 1/16 dB. Attack smoothing, applying the gain and any serial framing are not part of this block.

Top module: `drc_gain_calc`

## Requirements
- R1: `curve_code` selects the curve as follows: 110 → curve 1, 101 → curve 2, 100 → curve 3, 010 → curve 4, 001 → curve 5, 000 → curve 6, and 011 or 111 → bypass. The code is sampled on the clock edge that loads the outputs.
- R2: A sample's magnitude is its absolute value, so -32768 gives 32768. The held value of the sample's channel becomes the larger of the magnitude × 2^13 and the decayed held value. A louder sample therefore shows in the level with no delay.
- R3: Each sample first decays its channel's held value H to H − floor(H / 2^13). The reported magnitude is floor(H / 2^13). Without a louder input, the level never rises and falls as the model predicts.
- R4: Each channel has its own held value. A sample on one channel leaves the other channel's held value untouched. Reset clears both held values to zero.
- R5: The level is computed from the magnitude M. Let p be the position of the leading one and f the 8 bits that follow it, zero-filled. Then L = (p − 15)·256 + f, and level_db = floor(L·1541 / 2^12) in 1/16 dB. M = 0, and any result below −1536 (−96 dB), gives −1536.
- R6: The gain is clamp(C − floor(level_db / 2), FLOOR, BOOST), all in 1/16 dB. The constants are curve 1: BOOST 320, C −160, FLOOR −160; curve 2: 240, −64, −64; curve 4: 240, −80, −80. This gives +20/+15/+15 dB below the knee and a 2:1 slope up to 0 dBFS.
- R7: Curve 5 uses BOOST 240, C −80, FLOOR 0. Curve 6 uses BOOST 288, C −144, FLOOR 0. Both return to unity gain above −10 dBFS and above −18 dBFS respectively.
- R8: Curve 3 is curve 6 with every constant lowered by the parameter CURVE3_CUT_DB × 16. With the default of 18 dB, curve 3 runs from 0 dB gain down to −18 dB.
- R9: Both bypass codes give a gain of exactly 0 whatever the level.
- R10: `gain_valid` is high for exactly one cycle, two rising edges after the edge that accepts `smp_valid`, and `gain_chan` carries that sample's channel. In cycles without a result, `gain_db` and `level_db` keep their last values.
- R11: While `rst` is high and just after it is released, `gain_valid`, `gain_chan`, `gain_db` and `level_db` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_chan | input | 1 | Channel of the sample (0 left, 1 right) |
| smp_data | input | 16 | Two's-complement audio sample |
| curve_code | input | 3 | Compression curve selection code |
| gain_valid | output | 1 | Gain result strobe |
| gain_chan | output | 1 | Channel of the result |
| gain_db | output | 12 | Signed gain, 1/16 dB units |
| level_db | output | 12 | Signed detected level, 1/16 dBFS units |

## Verification
The bench targets several specific mistakes:
- A full-scale negative sample. A design that takes the magnitude in 16 signed bits would read it as negative or as zero and report the wrong level.
- A zero-magnitude input. It must clamp to −96 dB; a design that misses this would emit a bogus level from its leading-one search.
- Gains that land exactly on the knees and just inside them. A design with a wrong clamp order or the wrong rounding of the halved level would miss by one LSB.
- A long run of silence. It checks every step of the exponential decay, and that one channel's traffic never disturbs the other's held peak. Decay applied on every cycle, or a single shared peak register, would fail here.

// File: rtl/drcg_pkg.sv
`timescale 1ns/1ps
package drcg_pkg;

    // Fixed-point dB word: signed, DB_FRAC fraction bits
    localparam int DB_W     = 12;
    localparam int DB_FRAC  = 4;
    localparam int DB_MIN_Q = -96 * (1 << DB_FRAC);

    typedef logic signed [DB_W-1:0] db_t;

    typedef enum logic [2:0] {
        MODE_C6    = 3'b000,
        MODE_C5    = 3'b001,
        MODE_C4    = 3'b010,
        MODE_OFF_A = 3'b011,
        MODE_C3    = 3'b100,
        MODE_C2    = 3'b101,
        MODE_C1    = 3'b110,
        MODE_OFF_B = 3'b111
    } mode_code_e;

    // gain = clamp(knee_c - level/2, floor_q, boost)
    typedef struct packed {
        db_t boost;
        db_t knee_c;
        db_t floor_q;
    } curve_cfg_t;

    function automatic db_t dbq(input int whole_db);
        return db_t'(whole_db * (1 << DB_FRAC));
    endfunction

    function automatic curve_cfg_t make_cfg(input int b, input int c, input int f);
        curve_cfg_t r;
        r.boost   = dbq(b);
        r.knee_c  = dbq(c);
        r.floor_q = dbq(f);
        return r;
    endfunction

    function automatic curve_cfg_t curve_lookup(input mode_code_e code, input int cut_db);
        curve_cfg_t r;
        case (code)
            MODE_C1: r = make_cfg(20, -10, -10);
            MODE_C2: r = make_cfg(15, -4, -4);
            MODE_C3: r = make_cfg(18 - cut_db, -9 - cut_db, -cut_db);
            MODE_C4: r = make_cfg(15, -5, -5);
            MODE_C5: r = make_cfg(15, -5, 0);
            MODE_C6: r = make_cfg(18, -9, 0);
            default: r = make_cfg(0, 0, 0);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/drcg_peak_tracker.sv
`timescale 1ns/1ps
module drcg_peak_tracker #(
    parameter int SAMPLE_W    = 16,
    parameter int NUM_CH      = 2,
    parameter int DECAY_SHIFT = 13,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int HOLD_W     = SAMPLE_W + DECAY_SHIFT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [CH_W-1:0]            in_chan,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       out_valid,
    output logic [CH_W-1:0]            out_chan,
    output logic [SAMPLE_W-1:0]        out_mag
);

    logic [SAMPLE_W-1:0] mag;
    logic [HOLD_W-1:0]   held_q [NUM_CH];
    logic [HOLD_W-1:0]   cur_hold;
    logic [HOLD_W-1:0]   decayed;
    logic [HOLD_W-1:0]   fresh;
    logic [HOLD_W-1:0]   next_hold;

    always_comb begin
        mag       = in_sample[SAMPLE_W-1] ? SAMPLE_W'(~in_sample + 1'b1) : SAMPLE_W'(in_sample);
        cur_hold  = held_q[in_chan];
        decayed   = cur_hold - (cur_hold >> DECAY_SHIFT);
        fresh     = {mag, {DECAY_SHIFT{1'b0}}};
        next_hold = (fresh > decayed) ? fresh : decayed;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst)
                held_q[c] <= '0;
            else if (in_valid && in_chan == CH_W'(c))
                held_q[c] <= next_hold;
        end

        assert_hold_isolated_R4: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_chan != CH_W'(c)) |=> $stable(held_q[c]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_mag   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_chan <= in_chan;
                out_mag  <= next_hold[HOLD_W-1 -: SAMPLE_W];
            end
        end
    end

    assert_peak_covers_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_mag >= $past(mag)));

endmodule

// File: rtl/drcg_level_to_db.sv
`timescale 1ns/1ps
module drcg_level_to_db
    import drcg_pkg::*;
#(
    parameter int MAG_W       = 16,
    parameter int LOG_FRAC    = 8,
    parameter int DB_SCALE_Q8 = 1541,
    localparam int SHIFT      = LOG_FRAC + 8 - DB_FRAC
) (
    input  logic [MAG_W-1:0] mag,
    output db_t              level
);

    int         lead_pos;
    logic       any_one;
    logic [MAG_W-1:0] norm;
    int         frac_val;
    int         log_q;
    int         scaled;

    always_comb begin
        lead_pos = 0;
        any_one  = 1'b0;
        for (int i = 0; i < MAG_W; i++) begin
            if (mag[i]) begin
                lead_pos = i;
                any_one  = 1'b1;
            end
        end
        norm     = mag << (MAG_W - 1 - lead_pos);
        frac_val = (int'(norm) - (1 << (MAG_W - 1))) >>> (MAG_W - 1 - LOG_FRAC);
        log_q    = (lead_pos - (MAG_W - 1)) * (1 << LOG_FRAC) + frac_val;
        scaled   = (log_q * DB_SCALE_Q8) >>> SHIFT;
        if (!any_one || scaled < DB_MIN_Q)
            level = db_t'(DB_MIN_Q);
        else
            level = db_t'(scaled);
    end

endmodule

// File: rtl/drcg_curve_gain.sv
`timescale 1ns/1ps
module drcg_curve_gain
    import drcg_pkg::*;
#(
    parameter int CURVE3_CUT_DB = 18
) (
    input  mode_code_e mode,
    input  db_t        level,
    output db_t        gain
);

    localparam int WIDE = DB_W + 2;

    curve_cfg_t              cfg;
    logic signed [WIDE-1:0]  raw;
    logic signed [WIDE-1:0]  hi;
    logic signed [WIDE-1:0]  lo;

    always_comb begin
        cfg = curve_lookup(mode, CURVE3_CUT_DB);
        raw = WIDE'(cfg.knee_c) - WIDE'(level >>> 1);
        hi  = WIDE'(cfg.boost);
        lo  = WIDE'(cfg.floor_q);
        if (raw > hi)
            gain = cfg.boost;
        else if (raw < lo)
            gain = cfg.floor_q;
        else
            gain = db_t'(raw);
    end

endmodule

// File: rtl/drc_gain_calc.sv
`timescale 1ns/1ps
module drc_gain_calc
    import drcg_pkg::*;
#(
    parameter int SAMPLE_W      = 16,
    parameter int NUM_CH        = 2,
    parameter int DECAY_SHIFT   = 13,
    parameter int LOG_FRAC      = 8,
    parameter int CURVE3_CUT_DB = 18,
    localparam int CH_W         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_valid,
    input  logic [CH_W-1:0]            smp_chan,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic [2:0]                 curve_code,
    output logic                       gain_valid,
    output logic [CH_W-1:0]            gain_chan,
    output logic signed [DB_W-1:0]     gain_db,
    output logic signed [DB_W-1:0]     level_db
);

    localparam int GAIN_HI = 20 * (1 << DB_FRAC);
    localparam int GAIN_LO = (CURVE3_CUT_DB > 10) ? -CURVE3_CUT_DB * (1 << DB_FRAC)
                                                  : -10 * (1 << DB_FRAC);

    logic                pk_valid;
    logic [CH_W-1:0]     pk_chan;
    logic [SAMPLE_W-1:0] pk_mag;
    db_t                 lvl_now;
    db_t                 gain_now;

    drcg_peak_tracker #(
        .SAMPLE_W    (SAMPLE_W),
        .NUM_CH      (NUM_CH),
        .DECAY_SHIFT (DECAY_SHIFT)
    ) u_peak (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (smp_valid),
        .in_chan   (smp_chan),
        .in_sample (smp_data),
        .out_valid (pk_valid),
        .out_chan  (pk_chan),
        .out_mag   (pk_mag)
    );

    drcg_level_to_db #(
        .MAG_W    (SAMPLE_W),
        .LOG_FRAC (LOG_FRAC)
    ) u_log (
        .mag   (pk_mag),
        .level (lvl_now)
    );

    drcg_curve_gain #(
        .CURVE3_CUT_DB (CURVE3_CUT_DB)
    ) u_curve (
        .mode  (mode_code_e'(curve_code)),
        .level (lvl_now),
        .gain  (gain_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_valid <= 1'b0;
            gain_chan  <= '0;
            gain_db    <= '0;
            level_db   <= '0;
        end else begin
            gain_valid <= pk_valid;
            if (pk_valid) begin
                gain_chan <= pk_chan;
                gain_db   <= gain_now;
                level_db  <= lvl_now;
            end
        end
    end

    assert_result_latency_R10: assert property (@(posedge clk) disable iff (rst)
        gain_valid |-> ($past(smp_valid, 2) && gain_chan == $past(smp_chan, 2)));

    assert_bypass_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (gain_valid && ($past(curve_code) == 3'b011 || $past(curve_code) == 3'b111))
        |-> (gain_db == '0));

    assert_level_range_R5: assert property (@(posedge clk) disable iff (rst)
        gain_valid |-> (level_db >= db_t'(DB_MIN_Q) && level_db <= db_t'(0)));

    assert_gain_span_R6: assert property (@(posedge clk) disable iff (rst)
        gain_valid |-> (gain_db <= db_t'(GAIN_HI) && gain_db >= db_t'(GAIN_LO)));

endmodule

// File: tb/test_drc_gain_calc.sv
`timescale 1ns/1ps
module test_drc_gain_calc;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              smp_valid = 1'b0;
    logic              smp_chan = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic [2:0]        curve_code = 3'b110;
    logic              gain_valid;
    logic              gain_chan;
    logic signed [11:0] gain_db;
    logic signed [11:0] level_db;

    int n_cmp = 0;
    int n_bad = 0;
    longint hm [2];
    int exp_lvl;
    int exp_gain;

    always #5 clk = ~clk;

    drc_gain_calc i_drc_gain_calc (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .smp_chan   (smp_chan),
        .smp_data   (smp_data),
        .curve_code (curve_code),
        .gain_valid (gain_valid),
        .gain_chan  (gain_chan),
        .gain_db    (gain_db),
        .level_db   (level_db)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic [15:0] smp;
        int          lvl;
        int          gain;
    } vec_t;

    localparam vec_t VECS [15] = '{
        '{3'b110, 16'h8000,     0, -160},  // R6 full-scale negative, R2 magnitude
        '{3'b110, 16'd1024,  -482,   81},  // R6 slope region
        '{3'b110, 16'd32,    -964,  320},  // R6 boost clamp
        '{3'b101, 16'd4096,  -289,   81},  // R6 curve 2
        '{3'b101, 16'hF000,  -289,   81},  // R2 negative sample
        '{3'b010, 16'd16384,  -97,  -31},  // R6 curve 4
        '{3'b001, 16'd16384,  -97,    0},  // R7 unity region
        '{3'b001, 16'd512,   -578,  209},  // R7 slope region
        '{3'b000, 16'd4096,  -289,    1},  // R7 curve 6 near knee
        '{3'b000, 16'd1,    -1445,  288},  // R7 boost clamp
        '{3'b100, 16'd4096,  -289, -287},  // R8 curve 3
        '{3'b100, 16'h8000,     0, -288},  // R8 floor clamp
        '{3'b011, 16'd1024,  -482,    0},  // R9 bypass code A
        '{3'b111, 16'd32,    -964,    0},  // R9 bypass code B
        '{3'b110, 16'd0,    -1536,  320}   // R5 zero magnitude clamp
    };

    task automatic check(input string req, input string what, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    function automatic int m_db(input int mag);
        int p;
        int norm;
        int lq;
        int s;
        if (mag == 0) return -1536;
        p = 0;
        for (int i = 0; i < 16; i++) if ((mag >> i) & 1) p = i;
        norm = (mag << (15 - p)) & 16'hFFFF;
        lq = (p - 15) * 256 + ((norm >> 7) & 255);
        s = (lq * 1541) >>> 12;
        return (s < -1536) ? -1536 : s;
    endfunction

    function automatic int m_gain(input logic [2:0] code, input int lvl);
        int b, c, f, g;
        case (code)
            3'b110: begin b = 320; c = -160; f = -160; end
            3'b101: begin b = 240; c = -64;  f = -64;  end
            3'b100: begin b = 0;   c = -432; f = -288; end
            3'b010: begin b = 240; c = -80;  f = -80;  end
            3'b001: begin b = 240; c = -80;  f = 0;    end
            3'b000: begin b = 288; c = -144; f = 0;    end
            default: begin b = 0;  c = 0;    f = 0;    end
        endcase
        g = c - (lvl >>> 1);
        if (g > b) g = b;
        if (g < f) g = f;
        return g;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hm[0] = 0;
        hm[1] = 0;
    endtask

    task automatic push(input int ch, input logic [15:0] x, input logic [2:0] code);
        longint fr;
        longint dc;
        int mag;
        @(negedge clk);
        smp_valid  = 1'b1;
        smp_chan   = ch[0];
        smp_data   = x;
        curve_code = code;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        mag = x[15] ? (65536 - int'(x)) : int'(x);
        fr = longint'(mag) << 13;
        dc = hm[ch] - (hm[ch] >> 13);
        hm[ch] = (fr > dc) ? fr : dc;
        exp_lvl  = m_db(int'(hm[ch] >> 13));
        exp_gain = m_gain(code, exp_lvl);
    endtask

    initial begin
        #1_900_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int prev;
        logic signed [11:0] held_gain;
        hm[0] = 0;
        hm[1] = 0;

        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11", "gain_valid in reset", int'(gain_valid), 0);
        check("R11", "gain_db in reset", int'(gain_db), 0);
        check("R11", "level_db in reset", int'(level_db), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R11", "gain_chan after reset", int'(gain_chan), 0);

        // Vector table, each entry from a cleared peak on channel 0
        foreach (VECS[k]) begin
            do_reset();
            push(0, VECS[k].smp, VECS[k].code);
            check("R5", $sformatf("level vec %0d", k), int'(level_db), VECS[k].lvl);
            check("R6", $sformatf("gain vec %0d", k), int'(gain_db), VECS[k].gain);
        end

        // R10: latency and hold
        do_reset();
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = 1'b1; smp_data = 16'd4096; curve_code = 3'b110;
        @(negedge clk);
        smp_valid = 1'b0;
        check("R10", "valid after one edge", int'(gain_valid), 0);
        @(negedge clk);
        check("R10", "valid after two edges", int'(gain_valid), 1);
        check("R10", "channel tag", int'(gain_chan), 1);
        held_gain = gain_db;
        @(negedge clk);
        check("R10", "valid single cycle", int'(gain_valid), 0);
        check("R10", "gain held when idle", int'(gain_db), int'(held_gain));

        // R3: decay over silence, R2 instant attack
        do_reset();
        push(0, 16'd32767, 3'b110);
        check("R3", "start level", int'(level_db), exp_lvl);
        prev = int'(level_db);
        for (int n = 0; n < 3000; n++) begin
            push(0, 16'd0, 3'b110);
            check("R3", $sformatf("decay step %0d", n), int'(level_db), exp_lvl);
            if (int'(level_db) > prev)
                check("R3", "level rose during silence", int'(level_db), prev);
            prev = int'(level_db);
        end
        check("R3", "gain after decay", int'(gain_db), exp_gain);
        if (prev >= m_db(32767))
            check("R3", "level fell overall", prev, m_db(32767) - 1);
        push(0, 16'h8000, 3'b110);
        check("R2", "instant attack level", int'(level_db), 0);

        // R4: channel independence
        do_reset();
        push(1, 16'd30000, 3'b000);
        push(0, 16'd64, 3'b000);
        check("R4", "ch0 own level", int'(level_db), exp_lvl);
        check("R4", "ch0 tag", int'(gain_chan), 0);
        push(1, 16'd0, 3'b000);
        check("R4", "ch1 decayed level", int'(level_db), exp_lvl);
        check("R4", "ch1 tag", int'(gain_chan), 1);

        // R4: reset clears held peaks
        push(0, 16'd20000, 3'b000);
        do_reset();
        push(0, 16'd8, 3'b000);
        check("R4", "level after reset", int'(level_db), m_db(8));

        // R1: every code against one held level
        for (int cd = 0; cd < 8; cd++) begin
            push(0, 16'd2000, 3'(cd));
            check("R1", $sformatf("gain code %0d", cd), int'(gain_db), exp_gain);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule